// File: doc/BRIEF.md
# Nibble-Mode Reverse Byte Receiver

This block is the host side of a peripheral-to-host transfer over a parallel printer port that has already been placed in nibble mode. The peripheral has no way to drive the data lines in this mode. It sends each byte as two 4-bit halves on four status lines and strobes each half with its acknowledge line. The host paces every half with its auto-feed line, which it pulls low to ask for a nibble and releases to mark that it is busy.

A transfer begins with a one-cycle start pulse and a byte count. For each byte the block requests the low half and then the high half. It latches each half from synchronized copies of the status lines and assembles the byte. It offers the byte on a valid/ready output and counts the bytes the consumer accepts. The transfer ends with a done flag and a two-bit result code. The code separates a peripheral that never answered (timeout) from one that did not finish the closing handshake of a byte (I/O error). On any error the auto-feed line returns high. The byte counter then shows how many whole bytes were delivered.

Top module: `nibble_rev_rx`

## Requirements
- R1: After reset, `n_autofd_o`, `n_strobe_o` and `n_select_in_o` are 1, `byte_valid_o`, `done_o` and `byte_count_o` are 0, and `err_o` is 2'b00.
- R2: A `start` pulse in the idle state with a nonzero `req_count` drives `n_autofd_o` low, while `n_strobe_o` and `n_select_in_o` stay 1. A `start` pulse during a transfer is ignored: it changes neither the count in use nor the result.
- R3: Each status input is sampled through a two-flop synchronizer. When the synchronized `n_ack_i` is seen low, `n_autofd_o` rises and a nibble is latched with bit 0 = `n_fault_i`, bit 1 = `select_i`, bit 2 = `perror_i` and bit 3 = `busy_i`. The block then waits for `n_ack_i` to return high before it requests the next nibble.
- R4: The first nibble of each byte forms bits 3:0 and the second forms bits 7:4. The byte appears on `byte_o` with `byte_valid_o` only after both halves are latched and the closing handshake has completed. It stays stable until `byte_ready_i` is high. `byte_count_o` increments once per accepted byte.
- R5: The wait for `n_ack_i` low on the first nibble of a byte lasts up to `IDLE_LIMIT` cycles. On the second nibble the wait lasts only up to `RESP_LIMIT` cycles. Expiry of either wait ends the transfer with `err_o` = 2'b01 (timeout).
- R6: If `n_ack_i` does not return high within `RESP_LIMIT` cycles after the first nibble, the result is 2'b01 (timeout). If it does not return high after the second nibble, the result is 2'b10 (I/O error), and that byte is not delivered.
- R7: When `req_count` bytes have been accepted, `done_o` goes to 1 with `err_o` = 2'b00 and `byte_count_o` = `req_count`. Both stay unchanged until the next `start`.
- R8: On any error, `n_autofd_o` returns to 1, `done_o` goes to 1 and `byte_count_o` holds the number of bytes accepted before the failure.
- R9: A `start` with `req_count` = 0 sets `done_o` on the next cycle with `err_o` = 2'b00 and `byte_count_o` = 0, and `n_autofd_o` never goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a transfer |
| req_count | input | CNT_W | Number of bytes to receive, sampled at start |
| n_fault_i | input | 1 | Fault status line (nibble bit 0) |
| select_i | input | 1 | Select status line (nibble bit 1) |
| perror_i | input | 1 | Paper-error status line (nibble bit 2) |
| busy_i | input | 1 | Busy status line (nibble bit 3) |
| n_ack_i | input | 1 | Peripheral nibble strobe, active low |
| byte_ready_i | input | 1 | Consumer accepts the offered byte |
| n_select_in_o | output | 1 | Host select level, held high |
| n_strobe_o | output | 1 | Host strobe level, held high |
| n_autofd_o | output | 1 | Host nibble request (low) / host busy (high) |
| byte_o | output | 8 | Assembled byte |
| byte_valid_o | output | 1 | A byte is offered on byte_o |
| byte_count_o | output | CNT_W | Bytes accepted in the current or last transfer |
| done_o | output | 1 | Transfer finished; held until the next start |
| err_o | output | 2 | 00 ok, 01 timeout, 10 I/O error |

## Verification
A wrong handshake state shows up at the ports within a few cycles. `n_autofd_o` stays low or stays high when the synchronized acknowledge edge should have flipped it, and the peripheral model then stalls until a timeout reports a result other than the expected one. A mix-up in nibble order or pin mapping changes the delivered byte values, which are compared one by one. A wrong timer selection moves the moment the transfer fails by hundreds of cycles: a peripheral that answers the first nibble after 100 cycles must succeed, and one that answers the second nibble after 20 cycles must fail. A counter or result-code fault is visible on `byte_count_o` and `err_o` as soon as `done_o` rises.

// File: rtl/nibble_rev_rx.sv
module nibble_rev_rx #(
  parameter int CNT_W      = 8,
  parameter int IDLE_LIMIT = 2000,
  parameter int RESP_LIMIT = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] req_count,
  input  logic             n_fault_i,
  input  logic             select_i,
  input  logic             perror_i,
  input  logic             busy_i,
  input  logic             n_ack_i,
  input  logic             byte_ready_i,
  output logic             n_select_in_o,
  output logic             n_strobe_o,
  output logic             n_autofd_o,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  output logic [CNT_W-1:0] byte_count_o,
  output logic             done_o,
  output logic [1:0]       err_o
);
  localparam int MAXLIM = (IDLE_LIMIT > RESP_LIMIT) ? IDLE_LIMIT : RESP_LIMIT;
  localparam int TMR_W  = $clog2(MAXLIM) + 1;
  localparam logic [TMR_W-1:0] IDLE_LAST = TMR_W'(IDLE_LIMIT - 1);
  localparam logic [TMR_W-1:0] RESP_LAST = TMR_W'(RESP_LIMIT - 1);
  localparam logic [1:0] ERR_NONE = 2'b00;
  localparam logic [1:0] ERR_TMO  = 2'b01;
  localparam logic [1:0] ERR_IO   = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_REQ_LO, S_ACK_LO, S_REQ_HI, S_ACK_HI, S_OUT} st_t;

  st_t              st;
  logic [4:0]       sync1, sync2;
  logic [TMR_W-1:0] tmr;
  logic [3:0]       lo_nib;
  logic [7:0]       byte_q;
  logic [CNT_W-1:0] req_q, cnt_q;
  logic             autofd_q, done_q;
  logic [1:0]       err_q;

  wire             ack_s   = sync2[4];
  wire [3:0]       nib_s   = sync2[3:0];
  wire             want_lo = (st == S_REQ_LO) || (st == S_REQ_HI);
  wire             waiting = want_lo || (st == S_ACK_LO) || (st == S_ACK_HI);
  wire             cond    = want_lo ? !ack_s : ack_s;
  wire [TMR_W-1:0] limit   = (st == S_REQ_LO) ? IDLE_LAST : RESP_LAST;
  wire             expire  = waiting && !cond && (tmr == limit);
  wire [CNT_W-1:0] cnt_nx  = cnt_q + 1'b1;

  assign n_select_in_o = 1'b1;
  assign n_strobe_o    = 1'b1;
  assign n_autofd_o    = autofd_q;
  assign byte_o        = byte_q;
  assign byte_valid_o  = (st == S_OUT);
  assign byte_count_o  = cnt_q;
  assign done_o        = done_q;
  assign err_o         = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
    end else begin
      sync1 <= {n_ack_i, busy_i, perror_i, select_i, n_fault_i};
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tmr <= '0;
    else if (!waiting || cond) tmr <= '0;
    else if (!expire)          tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      lo_nib   <= '0;
      byte_q   <= '0;
      req_q    <= '0;
      cnt_q    <= '0;
      autofd_q <= 1'b1;
      done_q   <= 1'b0;
      err_q    <= ERR_NONE;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done_q <= (req_count == '0);
          err_q  <= ERR_NONE;
          cnt_q  <= '0;
          req_q  <= req_count;
          if (req_count != '0) begin
            st       <= S_REQ_LO;
            autofd_q <= 1'b0;
          end
        end
        S_REQ_LO: if (cond) begin
          lo_nib   <= nib_s;
          autofd_q <= 1'b1;
          st       <= S_ACK_LO;
        end else if (expire) begin
          st <= S_IDLE; autofd_q <= 1'b1; done_q <= 1'b1; err_q <= ERR_TMO;
        end
        S_ACK_LO: if (cond) begin
          autofd_q <= 1'b0;
          st       <= S_REQ_HI;
        end else if (expire) begin
          st <= S_IDLE; autofd_q <= 1'b1; done_q <= 1'b1; err_q <= ERR_TMO;
        end
        S_REQ_HI: if (cond) begin
          byte_q   <= {nib_s, lo_nib};
          autofd_q <= 1'b1;
          st       <= S_ACK_HI;
        end else if (expire) begin
          st <= S_IDLE; autofd_q <= 1'b1; done_q <= 1'b1; err_q <= ERR_TMO;
        end
        S_ACK_HI: if (cond) begin
          st <= S_OUT;
        end else if (expire) begin
          st <= S_IDLE; autofd_q <= 1'b1; done_q <= 1'b1; err_q <= ERR_IO;
        end
        S_OUT: if (byte_ready_i) begin
          cnt_q <= cnt_nx;
          if (cnt_nx == req_q) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st       <= S_REQ_LO;
            autofd_q <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_o));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_count_o != $past(byte_count_o)) && !$past(start) |-> $past(byte_valid_o && byte_ready_i));

  // R3
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> n_autofd_o);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> n_autofd_o && !byte_valid_o);

  // R5
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != ERR_NONE) |-> done_o);

  // R6
  io_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) && (err_o == ERR_IO) |-> $past(st) == S_ACK_HI);

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) && start |=> $stable(req_q));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (err_o == ERR_NONE) |-> byte_count_o == req_q);
endmodule

// File: tb/tb_nibble_rev_rx.sv
`timescale 1ns/1ps
module tb_nibble_rev_rx;
  localparam int CNT_W = 8;
  localparam int NV = 7;
  localparam int V_CNT  [NV] = '{4,   1,   3,   3,   3,   5,   2};
  localparam int V_SEED [NV] = '{165, 15,  240, 60,  129, 90,  51};
  localparam int V_D1   [NV] = '{3,   100, 2,   2,   2,   1,   2};
  localparam int V_D2   [NV] = '{3,   5,   12,  20,  2,   1,   2};
  localparam int V_REL  [NV] = '{2,   1,   3,   1,   1,   0,   30};
  localparam int V_DROP [NV] = '{-1,  -1,  -1,  -1,  1,   -1,  -1};
  localparam int V_ERR  [NV] = '{0,   0,   0,   1,   2,   0,   1};
  localparam int V_N    [NV] = '{4,   1,   3,   0,   1,   5,   0};
  localparam string V_TAG [NV] = '{"R4", "R5", "R5", "R5", "R6", "R3", "R6"};

  logic clk = 0, rst_n = 0, start = 0, byte_ready = 1;
  logic [CNT_W-1:0] req_count = 0;
  logic n_fault = 0, sel = 0, pe = 0, bsy = 0, n_ack = 1;
  logic n_select_in_o, n_strobe_o, n_autofd_o, byte_valid_o, done_o;
  logic [7:0] byte_o;
  logic [CNT_W-1:0] byte_count_o;
  logic [1:0] err_o;

  int checks = 0, fails = 0;
  int p_d1 = 1, p_d2 = 1, p_rel = 1, p_dropat = -1, nib = 0;
  logic [7:0] p_seed = 0;
  logic [7:0] got [16];
  int got_n;

  always #5 clk = ~clk;

  nibble_rev_rx #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_count(req_count),
    .n_fault_i(n_fault), .select_i(sel), .perror_i(pe), .busy_i(bsy), .n_ack_i(n_ack),
    .byte_ready_i(byte_ready), .n_select_in_o(n_select_in_o), .n_strobe_o(n_strobe_o),
    .n_autofd_o(n_autofd_o), .byte_o(byte_o), .byte_valid_o(byte_valid_o),
    .byte_count_o(byte_count_o), .done_o(done_o), .err_o(err_o));

  function automatic logic [7:0] exp_byte(logic [7:0] seed, int i);
    return seed ^ 8'((i * 59) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // peripheral model
  initial begin
    int bi, d;
    bit hi;
    logic [7:0] b;
    logic [3:0] v;
    forever begin
      @(negedge clk);
      if (rst_n && !n_autofd_o) begin
        bi = nib / 2;
        hi = (nib % 2) == 1;
        d  = hi ? p_d2 : p_d1;
        b  = exp_byte(p_seed, bi);
        v  = hi ? b[7:4] : b[3:0];
        if (d < 0) begin
          while (!n_autofd_o) @(negedge clk);
        end else begin
          repeat (d) @(negedge clk);
          if (!n_autofd_o) begin
            {bsy, pe, sel, n_fault} = v;
            n_ack = 0;
            while (!n_autofd_o) @(negedge clk);
            if (!(hi && bi == p_dropat)) begin
              repeat (p_rel) @(negedge clk);
              n_ack = 1;
            end
            nib++;
          end
        end
      end
    end
  end

  task automatic collect(int max_cycles);
    got_n = 0;
    for (int c = 0; c < max_cycles; c++) begin
      @(negedge clk);
      byte_ready = (c % 3) != 2;
      if (byte_valid_o && byte_ready && got_n < 16) begin
        got[got_n] = byte_o;
        got_n++;
      end
      if (done_o) break;
    end
    byte_ready = 1;
  endtask

  task automatic settle();
    repeat (50) @(negedge clk);
    n_ack = 1;
    nib = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic kick(int cnt);
    @(negedge clk);
    req_count = CNT_W'(cnt);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_vec(int cnt, int seed, int d1, int d2, int rel, int dropat,
                         int eerr, int en, string tag);
    p_seed = 8'(seed); p_d1 = d1; p_d2 = d2; p_rel = rel; p_dropat = dropat;
    kick(cnt);
    collect(20000);
    chk(done_o === 1'b1, {tag, " done"}, done_o, 1);
    chk(err_o === 2'(eerr), {tag, " err code"}, err_o, eerr);
    chk(byte_count_o === CNT_W'(en), {tag, "/R8 byte count"}, byte_count_o, en);
    chk(got_n == en, {tag, " bytes delivered"}, got_n, en);
    for (int i = 0; i < en && i < got_n; i++)
      chk(got[i] === exp_byte(8'(seed), i), {tag, "/R4 byte value"}, got[i], exp_byte(8'(seed), i));
    chk(n_autofd_o === 1'b1, "R8 autofd released", n_autofd_o, 1);
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int seen_low;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(n_autofd_o === 1 && n_strobe_o === 1 && n_select_in_o === 1, "R1 host lines", n_autofd_o, 1);
    chk(byte_valid_o === 0 && done_o === 0, "R1 valid/done", done_o, 0);
    chk(err_o === 2'b00 && byte_count_o === 0, "R1 err/count", err_o, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NV; k++)
      run_vec(V_CNT[k], V_SEED[k], V_D1[k], V_D2[k], V_REL[k], V_DROP[k], V_ERR[k], V_N[k], V_TAG[k]);

    // R9 zero count
    kick(0);
    chk(done_o === 1 && err_o === 2'b00 && byte_count_o === 0, "R9 zero request done", done_o, 1);
    seen_low = 0;
    repeat (20) begin @(negedge clk); if (!n_autofd_o) seen_low++; end
    chk(seen_low == 0, "R9 no nibble request", seen_low, 0);
    settle();

    // R5 first nibble waits the idle limit; R8 release after timeout
    p_seed = 8'h11; p_d1 = -1; p_d2 = 1; p_rel = 1; p_dropat = -1;
    kick(2);
    chk(n_autofd_o === 0 && n_strobe_o === 1 && n_select_in_o === 1, "R2 request levels", n_autofd_o, 0);
    repeat (1000) @(negedge clk);
    chk(done_o === 0 && n_autofd_o === 0, "R5 still waiting past short window", done_o, 0);
    collect(5000);
    chk(done_o === 1 && err_o === 2'b01, "R5 idle-limit timeout code", err_o, 1);
    chk(byte_count_o === 0 && n_autofd_o === 1, "R8 count and release after timeout", byte_count_o, 0);
    settle();

    // R2 start during a transfer is ignored
    p_seed = 8'h6E; p_d1 = 2; p_d2 = 2; p_rel = 1; p_dropat = -1;
    kick(3);
    repeat (5) @(negedge clk);
    req_count = 8'd7; start = 1;
    @(negedge clk); start = 0;
    collect(20000);
    chk(err_o === 2'b00 && byte_count_o === 3, "R2 mid-run start ignored", byte_count_o, 3);
    for (int i = 0; i < 3 && i < got_n; i++)
      chk(got[i] === exp_byte(8'h6E, i), "R2 byte value", got[i], exp_byte(8'h6E, i));

    // R7 result held until next start
    repeat (30) @(negedge clk);
    chk(done_o === 1 && byte_count_o === 3 && err_o === 2'b00, "R7 result held", byte_count_o, 3);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule